// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block arbitrates between six interrupt requests: two active-low external pins, two timer requests, one serial request and a third timer whose request is the OR of two status flags. It runs on a machine cycle of `CYC` clocks. In one fixed slot of every machine cycle it looks at the request flags and picks at most one winner. It then raises a one-clock vector-taken strobe together with the winner's vector index.

Every source has an enable bit and a priority-level bit. One global enable also gates all six. A high-level request beats any low-level one. Among requests of the same level, the lower index wins. The controller keeps one in-service bit per level. While a routine is in service, only a request of a strictly higher level can be accepted. A return-from-interrupt pulse clears the highest in-service bit, and it also blocks the next sample slot.

Each external pin can be set to edge mode or level mode. In edge mode, the flag is set when the pin is high at one sample and low at the next, and taking the vector clears it. In level mode, the flag is the inverted pin as seen at the last sample, and the hardware never clears it.

The control flow is a three-state machine:
- `ST_ARMED` goes to `ST_TAKE` at a sample slot where an eligible winner exists, and goes to `ST_BLOCKED` on a return pulse.
- `ST_TAKE` lasts one clock and drives the strobe. It goes back to `ST_ARMED`, or to `ST_BLOCKED` if a return pulse arrives in that clock.
- `ST_BLOCKED` swallows the next sample slot and then goes back to `ST_ARMED`.

Top module: `irq2_arbiter`

## Requirements
- R1: Requests are evaluated only when the machine-cycle counter is at slot `SLOT` (9 of 0..11, counted from reset release). `vec_take` is high for exactly one clock, the clock after that slot.
- R2: Source indices are 0 external pin 0, 1 timer 0, 2 external pin 1, 3 timer 1, 4 serial, 5 timer 2. These are bit positions in `src_en`/`src_hi` and the values of `vec_idx`. Within one level, the lowest pending index wins.
- R3: A pending source whose `src_hi` bit is 1 wins over every pending source whose bit is 0, whatever their indices.
- R4: A source takes part only when its `src_en` bit is 1 and `glob_en` is 1.
- R5: No vector is taken while the high in-service bit is set. A low-level vector is taken only when neither in-service bit is set. A high-level request preempts a low-level routine.
- R6: `reti_pulse` clears the high in-service bit if it is set, and otherwise clears the low one. No vector is taken at the first sample slot after the pulse.
- R7: With `ext_edge_sel[i]`=1, pin i's flag is set when the pin is 1 at one slot and 0 at the next. The flag is cleared when its vector is taken. A pin held low gives no further request.
- R8: With `ext_edge_sel[i]`=0, pin i's flag equals the inverted pin sampled at the last slot. Taking the vector does not clear it.
- R9: Timer 0, timer 1 and serial requests are level inputs sampled at the slot. The timer-2 request is `t2_flags[0] | t2_flags[1]`.
- R10: Reset clears both in-service bits, both pin flags, the strobe and the index (0), and restarts the machine-cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one oscillator period |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin_n | input | 2 | External request pins, active low |
| ext_edge_sel | input | 2 | Per pin: 1 edge mode, 0 level mode |
| tmr_req | input | 2 | Timer 0 (bit 0) and timer 1 (bit 1) requests |
| ser_req | input | 1 | Serial request |
| t2_flags | input | 2 | The two timer-2 flags, ORed |
| src_en | input | 6 | Per-source enable, by index |
| glob_en | input | 1 | Global enable |
| src_hi | input | 6 | Per-source level, 1 = high |
| reti_pulse | input | 1 | Return-from-interrupt pulse |
| vec_take | output | 1 | One-clock vector-taken strobe |
| vec_idx | output | 3 | Index of the taken source |

## Verification
The bench targets nesting:
- A same-level request arriving during service must wait. A design that compared levels with "greater or equal" would nest it.
- A high request must still preempt a low routine.

It checks the sample slot right after a return pulse. A design without the block would issue a vector there.

It holds an edge-mode pin low for several machine cycles. A design that treated edges as levels would fire again. In level mode, a pin left low must fire again after each return. A design that wrongly cleared the flag on take would stay silent.

Ties within a level and a high request at a higher index are checked against the fixed order. Reset in the middle of a routine must leave no stale in-service bit.

// File: rtl/irq2_pkg.sv
package irq2_pkg;
    localparam int NSRC = 6;
    localparam int IDXW = $clog2(NSRC);

    localparam int SRC_X0  = 0;
    localparam int SRC_T0  = 1;
    localparam int SRC_X1  = 2;
    localparam int SRC_T1  = 3;
    localparam int SRC_SER = 4;
    localparam int SRC_T2  = 5;

    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,
        ST_TAKE    = 2'd1,
        ST_BLOCKED = 2'd2
    } arb_state_t;
endpackage

// File: rtl/mc_phase_gen.sv
module mc_phase_gen #(
    parameter int CYC  = 12,
    parameter int SLOT = 9
) (
    input  logic clk,
    input  logic rst_n,
    output logic slot
);
    localparam int CW = $clog2(CYC);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt == CW'(CYC - 1))
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign slot = (cnt == CW'(SLOT));

    // R1: the counter never leaves its machine-cycle range
    assert_phase_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(CYC));
endmodule

// File: rtl/xirq_detect.sv
module xirq_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic slot,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic flag
);
    logic prev_smp;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_smp <= 1'b1;
            flag     <= 1'b0;
        end else if (slot) begin
            prev_smp <= pin_n;
            if (edge_mode) begin
                if (prev_smp && !pin_n)
                    flag <= 1'b1;
            end else begin
                flag <= !pin_n;
            end
        end else if (clr && edge_mode) begin
            flag <= 1'b0;
        end
    end

    // R7: a high-to-low pair of samples raises the flag
    assert_edge_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (slot && edge_mode && prev_smp && !pin_n) |=> flag);

    // R8: taking the vector leaves a level-mode flag untouched
    assert_level_not_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !slot && !edge_mode) |=> (flag == $past(flag)));
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
    parameter int N  = 6,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq2_arbiter.sv
module irq2_arbiter
    import irq2_pkg::*;
#(
    parameter int CYC  = 12,
    parameter int SLOT = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      ext_pin_n,
    input  logic [1:0]      ext_edge_sel,
    input  logic [1:0]      tmr_req,
    input  logic            ser_req,
    input  logic [1:0]      t2_flags,
    input  logic [NSRC-1:0] src_en,
    input  logic            glob_en,
    input  logic [NSRC-1:0] src_hi,
    input  logic            reti_pulse,
    output logic            vec_take,
    output logic [IDXW-1:0] vec_idx
);
    logic            slot;
    logic [1:0]      ext_flag;
    logic [1:0]      ext_clr;
    logic [NSRC-1:0] pend, elig, hi_req, lo_req;
    logic            hi_found, lo_found;
    logic [IDXW-1:0] hi_idx, lo_idx;
    logic            ok_hi, ok_lo, grant;
    logic            insvc_hi, insvc_lo;
    logic [IDXW-1:0] win_idx;
    logic            win_hi;
    arb_state_t      state, state_nx;

    mc_phase_gen #(.CYC(CYC), .SLOT(SLOT)) u_phase (
        .clk(clk), .rst_n(rst_n), .slot(slot)
    );

    localparam int XSRC [2] = '{SRC_X0, SRC_X1};

    for (genvar g = 0; g < 2; g++) begin : g_ext
        assign ext_clr[g] = (state == ST_TAKE) && (win_idx == IDXW'(XSRC[g]));
        xirq_detect u_det (
            .clk(clk), .rst_n(rst_n), .slot(slot),
            .pin_n(ext_pin_n[g]), .edge_mode(ext_edge_sel[g]),
            .clr(ext_clr[g]), .flag(ext_flag[g])
        );
    end

    always_comb begin
        pend          = '0;
        pend[SRC_X0]  = ext_flag[0];
        pend[SRC_T0]  = tmr_req[0];
        pend[SRC_X1]  = ext_flag[1];
        pend[SRC_T1]  = tmr_req[1];
        pend[SRC_SER] = ser_req;
        pend[SRC_T2]  = |t2_flags;
    end

    assign elig   = pend & src_en & {NSRC{glob_en}};
    assign hi_req = elig & src_hi;
    assign lo_req = elig & ~src_hi;

    prio_pick #(.N(NSRC), .IW(IDXW)) u_pick_hi (
        .req(hi_req), .found(hi_found), .idx(hi_idx)
    );
    prio_pick #(.N(NSRC), .IW(IDXW)) u_pick_lo (
        .req(lo_req), .found(lo_found), .idx(lo_idx)
    );

    assign ok_hi = hi_found && !insvc_hi;
    assign ok_lo = lo_found && !insvc_hi && !insvc_lo;
    assign grant = slot && !reti_pulse && (ok_hi || ok_lo);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_ARMED;
        else
            state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ARMED: begin
                if (reti_pulse)
                    state_nx = ST_BLOCKED;
                else if (grant)
                    state_nx = ST_TAKE;
            end
            ST_TAKE:    state_nx = reti_pulse ? ST_BLOCKED : ST_ARMED;
            ST_BLOCKED: if (slot) state_nx = ST_ARMED;
            default:    state_nx = ST_ARMED;
        endcase
    end

    // winner capture and in-service tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_idx  <= '0;
            win_hi   <= 1'b0;
            insvc_hi <= 1'b0;
            insvc_lo <= 1'b0;
        end else begin
            if (state == ST_ARMED && grant) begin
                win_idx <= ok_hi ? hi_idx : lo_idx;
                win_hi  <= ok_hi;
            end
            if (state == ST_TAKE) begin
                if (win_hi) insvc_hi <= 1'b1;
                else        insvc_lo <= 1'b1;
            end else if (reti_pulse) begin
                if (insvc_hi) insvc_hi <= 1'b0;
                else          insvc_lo <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        vec_take = 1'b0;
        unique case (state)
            ST_TAKE:  vec_take = 1'b1;
            default:  vec_take = 1'b0;
        endcase
        vec_idx = win_idx;
    end

    assert_single_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        vec_take |=> !vec_take);
    assert_take_after_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        vec_take |-> $past(slot));
    assert_global_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_take |-> $past(glob_en));
    assert_hi_not_nested_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_take |-> !insvc_hi);
    assert_lo_waits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_take && !win_hi) |-> !insvc_lo);
    assert_block_after_reti_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reti_pulse |=> !vec_take);
endmodule

// File: tb/test_irq2_arbiter.sv
module test_irq2_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ext_pin_n = 2'b11;
    logic [1:0] ext_edge_sel = 2'b00;
    logic [1:0] tmr_req = 2'b00;
    logic       ser_req = 1'b0;
    logic [1:0] t2_flags = 2'b00;
    logic [5:0] src_en = 6'h00;
    logic       glob_en = 1'b0;
    logic [5:0] src_hi = 6'h00;
    logic       reti_pulse = 1'b0;
    logic       vec_take;
    logic [2:0] vec_idx;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq2_arbiter i_irq2_arbiter (
        .clk(clk), .rst_n(rst_n), .ext_pin_n(ext_pin_n), .ext_edge_sel(ext_edge_sel),
        .tmr_req(tmr_req), .ser_req(ser_req), .t2_flags(t2_flags), .src_en(src_en),
        .glob_en(glob_en), .src_hi(src_hi), .reti_pulse(reti_pulse),
        .vec_take(vec_take), .vec_idx(vec_idx)
    );

    typedef struct packed {
        logic [1:0] p;
        logic [1:0] edg;
        logic [1:0] tm;
        logic       sr;
        logic [1:0] t2;
        logic [5:0] en;
        logic       ge;
        logic [5:0] hi;
        logic       rt;
        logic       xt;
        logic [2:0] xi;
        logic [3:0] rq;
    } vec_t;

    // one row per machine cycle: {pins, edge, timers, serial, t2, en, glob, hi, reti, take?, idx, req}
    localparam vec_t TBL [0:28] = '{
        '{2'b11,2'b00,2'b00,1'b0,2'b00,6'h3F,1'b1,6'h00,1'b0,1'b0,3'd0,4'd10}, // R10 idle
        '{2'b11,2'b00,2'b01,1'b0,2'b00,6'h3F,1'b1,6'h00,1'b0,1'b1,3'd1,4'd1},  // R1 timer0
        '{2'b11,2'b00,2'b01,1'b0,2'b00,6'h3F,1'b1,6'h00,1'b0,1'b0,3'd0,4'd5},  // R5 same level waits
        '{2'b11,2'b00,2'b01,1'b1,2'b00,6'h3F,1'b1,6'h10,1'b0,1'b1,3'd4,4'd5},  // R5 high preempts
        '{2'b11,2'b00,2'b01,1'b1,2'b00,6'h3F,1'b1,6'h10,1'b0,1'b0,3'd0,4'd5},  // R5 high busy
        '{2'b11,2'b00,2'b00,1'b1,2'b00,6'h3F,1'b1,6'h10,1'b1,1'b0,3'd0,4'd6},  // R6 blocked
        '{2'b11,2'b00,2'b00,1'b1,2'b00,6'h3F,1'b1,6'h10,1'b0,1'b1,3'd4,4'd6},  // R6 hi cleared
        '{2'b11,2'b00,2'b00,1'b0,2'b00,6'h3F,1'b1,6'h10,1'b1,1'b0,3'd0,4'd6},
        '{2'b11,2'b00,2'b00,1'b0,2'b00,6'h3F,1'b1,6'h00,1'b1,1'b0,3'd0,4'd6},
        '{2'b11,2'b00,2'b11,1'b0,2'b01,6'h3F,1'b1,6'h00,1'b0,1'b1,3'd1,4'd2},  // R2 tie
        '{2'b11,2'b00,2'b00,1'b0,2'b00,6'h3F,1'b1,6'h00,1'b1,1'b0,3'd0,4'd6},
        '{2'b11,2'b00,2'b10,1'b0,2'b10,6'h3F,1'b1,6'h20,1'b0,1'b1,3'd5,4'd9},  // R9 R3
        '{2'b11,2'b00,2'b00,1'b0,2'b00,6'h3F,1'b1,6'h00,1'b1,1'b0,3'd0,4'd6},
        '{2'b11,2'b00,2'b11,1'b0,2'b00,6'h3F,1'b0,6'h00,1'b0,1'b0,3'd0,4'd4},  // R4 global off
        '{2'b11,2'b00,2'b11,1'b0,2'b00,6'h3D,1'b1,6'h00,1'b0,1'b1,3'd3,4'd4},  // R4 mask
        '{2'b11,2'b00,2'b00,1'b0,2'b00,6'h3F,1'b1,6'h00,1'b1,1'b0,3'd0,4'd6},
        '{2'b01,2'b00,2'b00,1'b0,2'b00,6'h3F,1'b1,6'h00,1'b0,1'b0,3'd0,4'd8},  // R8 sampled
        '{2'b01,2'b00,2'b00,1'b0,2'b00,6'h3F,1'b1,6'h00,1'b0,1'b1,3'd2,4'd8},  // R8 pin1
        '{2'b11,2'b00,2'b00,1'b0,2'b00,6'h3F,1'b1,6'h00,1'b1,1'b0,3'd0,4'd6},
        '{2'b11,2'b01,2'b00,1'b0,2'b00,6'h3F,1'b1,6'h00,1'b0,1'b0,3'd0,4'd7},  // R7 high seen
        '{2'b10,2'b01,2'b00,1'b0,2'b00,6'h3F,1'b1,6'h00,1'b0,1'b0,3'd0,4'd7},  // R7 edge seen
        '{2'b10,2'b01,2'b00,1'b0,2'b00,6'h3F,1'b1,6'h00,1'b0,1'b1,3'd0,4'd7},  // R7 taken
        '{2'b10,2'b01,2'b00,1'b0,2'b00,6'h3F,1'b1,6'h00,1'b1,1'b0,3'd0,4'd6},
        '{2'b10,2'b01,2'b00,1'b0,2'b00,6'h3F,1'b1,6'h00,1'b0,1'b0,3'd0,4'd7},  // R7 held low
        '{2'b10,2'b00,2'b00,1'b0,2'b00,6'h3F,1'b1,6'h00,1'b0,1'b0,3'd0,4'd8},  // R8 sampled
        '{2'b10,2'b00,2'b00,1'b0,2'b00,6'h3F,1'b1,6'h00,1'b0,1'b1,3'd0,4'd8},  // R8 pin0
        '{2'b10,2'b00,2'b00,1'b0,2'b00,6'h3F,1'b1,6'h00,1'b1,1'b0,3'd0,4'd6},
        '{2'b10,2'b00,2'b00,1'b0,2'b00,6'h3F,1'b1,6'h00,1'b0,1'b1,3'd0,4'd8},  // R8 not cleared
        '{2'b11,2'b00,2'b00,1'b0,2'b00,6'h3F,1'b1,6'h00,1'b1,1'b0,3'd0,4'd6}
    };

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // one machine cycle from a negedge; R1 strobe expected at sample 10
    task automatic run_window(input vec_t v, input int row);
        int n_take = 0;
        int pos = 0;
        int idx = 0;
        ext_pin_n = v.p; ext_edge_sel = v.edg; tmr_req = v.tm; ser_req = v.sr;
        t2_flags = v.t2; src_en = v.en; glob_en = v.ge; src_hi = v.hi;
        reti_pulse = v.rt;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            reti_pulse = 1'b0;
            if (vec_take) begin
                n_take++;
                pos = k;
                idx = int'(vec_idx);
            end
        end
        check(n_take == int'(v.xt), $sformatf("R%0d row %0d strobe count", v.rq, row),
              n_take, int'(v.xt));
        if (v.xt) begin
            check(idx == int'(v.xi), $sformatf("R%0d row %0d index", v.rq, row), idx, int'(v.xi));
            check(pos == 10, $sformatf("R1 row %0d strobe position", row), pos, 10);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs quiet in reset
        check(vec_take == 1'b0, "R10 reset strobe", int'(vec_take), 0);
        check(vec_idx == 3'd0, "R10 reset index", int'(vec_idx), 0);
        rst_n = 1'b1;
        for (int r = 0; r < 29; r++) run_window(TBL[r], r);

        // R10: reset in the middle of a routine drops the in-service state
        run_window('{2'b11,2'b00,2'b01,1'b0,2'b00,6'h3F,1'b1,6'h00,1'b0,1'b1,3'd1,4'd10}, 100);
        run_window('{2'b11,2'b00,2'b01,1'b0,2'b00,6'h3F,1'b1,6'h00,1'b0,1'b0,3'd0,4'd5}, 101);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(vec_take == 1'b0, "R10 strobe under reset", int'(vec_take), 0);
        rst_n = 1'b1;
        run_window('{2'b11,2'b00,2'b01,1'b0,2'b00,6'h3F,1'b1,6'h00,1'b0,1'b1,3'd1,4'd10}, 102);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule